// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Controller

This block holds the control and status logic for the transmit side of one bulk IN endpoint in a USB device controller. Software loads a packet into an external FIFO. It then writes the packet length on `load_len_i` and sets the packet-ready bit in the control/status register. The block keeps track of how many committed packets are waiting, in one buffer slot or in two. It answers each IN token from the protocol engine with DATA, NAK or STALL. It keeps the DATA0/DATA1 toggle and raises a one-cycle interrupt whenever software needs to act.

The protocol engine reports how each DATA response ended. An acknowledge frees the slot and advances the toggle. A timeout leaves the packet queued so it is sent again with the same toggle. A stall request from software overrides everything else and stays in force until software removes it. Every STALL actually sent is recorded in a sticky flag. The FIFO RAM, the serial engine, CRC and DMA sit outside this block.

Top module: `bulk_in_tx_ctrl`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0 and the max-payload register (address 1) reads 0. `irq_o` and `rsp_valid_o` are low.
- R2: Writing address 0 with bit 0 set commits one packet of length `load_len_i` when a slot is free. Bit 0 reads 1 whenever no further packet can be accepted. A commit attempted while the buffer is full is ignored.
- R3: `tx_ack_i` after a DATA response frees the oldest slot, flips the data toggle and pulses `irq_o` for one cycle.
- R4: With `dbl_buf_en_i` high, two packets may be queued. The first commit into an empty buffer pulses `irq_o` and leaves bit 0 reading 0. The second commit sets bit 0 to 1 without an interrupt. Packets are sent in commit order.
- R5: `rsp_valid_o` is high for one cycle, one cycle after `in_token_i`, with `rsp_o` encoded as 2'b00 NAK, 2'b01 DATA and 2'b10 STALL. NAK is given when nothing is queued and no stall is requested.
- R6: `tx_timeout_i` after a DATA response keeps the packet queued and the toggle unchanged. The next token resends the same length with the same `rsp_pid_o` (0 = DATA0, 1 = DATA1).
- R7: A commit with length 0 is sent as a DATA response with `rsp_len_o` equal to 0.
- R8: The max-payload register keeps only its low 11 bits. `rsp_short_o` is 1 on a DATA response whose length is below the max payload.
- R9: While send-stall (bit 4) is set, every token gets STALL, taking priority over queued data. Each STALL sets sent-stall (bit 5) and pulses `irq_o`. Hardware never clears bit 4, and queued packets remain queued.
- R10: Writing 0 to bit 5 clears sent-stall. Writing 1 to bit 5 leaves it unchanged.
- R11: Writing 1 to bit 6 resets the toggle so the next DATA response carries DATA0. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_buf_en_i | input | 1 | Enables two-packet buffering |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control/status, 1 = max payload |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| load_len_i | input | 12 | Byte length of the packet being committed |
| in_token_i | input | 1 | IN token received, one-cycle pulse |
| tx_ack_i | input | 1 | Host acknowledged the last DATA packet |
| tx_timeout_i | input | 1 | Last DATA packet got no handshake |
| rsp_valid_o | output | 1 | Token response valid |
| rsp_o | output | 2 | Response code (NAK/DATA/STALL) |
| rsp_pid_o | output | 1 | Data toggle for a DATA response |
| rsp_len_o | output | 12 | Packet length for a DATA response |
| rsp_short_o | output | 1 | DATA length below max payload |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench commits a packet while the buffer is already full. It then checks that the length sent afterwards is the first packet's length: a design that overwrote or double-counted the slot would send 10 bytes or report the wrong ready state. A timeout followed by a resend must repeat DATA0, so a design that flips the toggle on any completion fails at once. In double-buffer mode the bench checks that the interrupt fires on the first commit only and that packets leave in commit order. The stall sequence checks that repeated tokens keep getting STALL, that writing 1 cannot clear sent-stall, and that the packet queued before the stall is still sent once the stall is lifted.

// File: rtl/bulk_in_pkg.sv
package bulk_in_pkg;
  typedef enum logic [1:0] {
    RSP_NAK   = 2'b00,
    RSP_DATA  = 2'b01,
    RSP_STALL = 2'b10
  } rsp_e;

  localparam int CSR_RDY        = 0;
  localparam int CSR_SEND_STALL = 4;
  localparam int CSR_SENT_STALL = 5;
  localparam int CSR_CLR_TOG    = 6;
endpackage

// File: rtl/bulk_in_slot_q.sv
module bulk_in_slot_q #(
  parameter int NSLOT = 2,
  parameter int LEN_W = 12,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LEN_W-1:0] push_len_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LEN_W-1:0] head_len_o
);
  logic [LEN_W-1:0] len_q [NSLOT];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NSLOT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  len_q[g] <= '0;
      else if (push_i && wr_ptr_q == PTR_W'(g))     len_q[g] <= push_len_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign head_len_o = len_q[rd_ptr_q];
endmodule

// File: rtl/bulk_in_resp.sv
module bulk_in_resp import bulk_in_pkg::*; #(
  parameter int LEN_W  = 12,
  parameter int MAXP_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              token_i,
  input  logic              send_stall_i,
  input  logic              have_pkt_i,
  input  logic [LEN_W-1:0]  head_len_i,
  input  logic [MAXP_W-1:0] maxp_i,
  input  logic              ack_i,
  input  logic              timeout_i,
  input  logic              clr_tog_i,
  output logic              stall_hit_o,
  output logic              pop_o,
  output logic              tog_o,
  output logic              rsp_vld_o,
  output logic [1:0]        rsp_o,
  output logic              pid_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              short_o
);
  rsp_e             rsp_q;
  logic             vld_q, pid_q, short_q, tog_q, inflight_q;
  logic [LEN_W-1:0] len_q;
  logic             send_data;

  assign stall_hit_o = token_i && send_stall_i;
  assign send_data   = token_i && !send_stall_i && have_pkt_i;
  assign pop_o       = ack_i && inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= 1'b0;
      rsp_q      <= RSP_NAK;
      pid_q      <= 1'b0;
      len_q      <= '0;
      short_q    <= 1'b0;
      tog_q      <= 1'b0;
      inflight_q <= 1'b0;
    end else begin
      vld_q <= token_i;
      if (token_i) begin
        rsp_q   <= stall_hit_o ? RSP_STALL : (send_data ? RSP_DATA : RSP_NAK);
        pid_q   <= tog_q;
        len_q   <= send_data ? head_len_i : '0;
        short_q <= send_data && (head_len_i < LEN_W'(maxp_i));
      end
      if (send_data)               inflight_q <= 1'b1;
      else if (ack_i || timeout_i) inflight_q <= 1'b0;
      // clear beats the flip on a same-cycle ack
      if (clr_tog_i)  tog_q <= 1'b0;
      else if (pop_o) tog_q <= ~tog_q;
    end
  end

  assign tog_o     = tog_q;
  assign rsp_vld_o = vld_q;
  assign rsp_o     = rsp_q;
  assign pid_o     = pid_q;
  assign len_o     = len_q;
  assign short_o   = short_q;
endmodule

// File: rtl/bulk_in_tx_ctrl.sv
module bulk_in_tx_ctrl import bulk_in_pkg::*; #(
  parameter int NSLOT  = 2,
  parameter int LEN_W  = 12,
  parameter int MAXP_W = 11,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(NSLOT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbl_buf_en_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [LEN_W-1:0]  load_len_i,
  input  logic              in_token_i,
  input  logic              tx_ack_i,
  input  logic              tx_timeout_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_o,
  output logic              rsp_pid_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic              rsp_short_o,
  output logic              irq_o
);
  logic [MAXP_W-1:0] maxp_q;
  logic              send_stall_q, sent_stall_q, irq_q;
  logic [CNT_W-1:0]  cnt, cap;
  logic [LEN_W-1:0]  head_len;
  logic              csr_we, maxp_we, full, push, pop, clr_tog, stall_hit, tog;
  logic [DATA_W-1:0] csr_rd;
  logic              unused_wdata;

  assign csr_we  = reg_we_i && !reg_addr_i;
  assign maxp_we = reg_we_i &&  reg_addr_i;
  assign cap     = dbl_buf_en_i ? CNT_W'(NSLOT) : CNT_W'(1);
  assign full    = cnt >= cap;
  assign push    = csr_we && reg_wdata_i[CSR_RDY] && !full;
  assign clr_tog = csr_we && reg_wdata_i[CSR_CLR_TOG];
  assign unused_wdata = ^reg_wdata_i;

  bulk_in_slot_q #(.NSLOT(NSLOT), .LEN_W(LEN_W)) u_slot_q (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_len_i (load_len_i),
    .pop_i      (pop),
    .cnt_o      (cnt),
    .head_len_o (head_len)
  );

  bulk_in_resp #(.LEN_W(LEN_W), .MAXP_W(MAXP_W)) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .token_i      (in_token_i),
    .send_stall_i (send_stall_q),
    .have_pkt_i   (cnt != '0),
    .head_len_i   (head_len),
    .maxp_i       (maxp_q),
    .ack_i        (tx_ack_i),
    .timeout_i    (tx_timeout_i),
    .clr_tog_i    (clr_tog),
    .stall_hit_o  (stall_hit),
    .pop_o        (pop),
    .tog_o        (tog),
    .rsp_vld_o    (rsp_valid_o),
    .rsp_o        (rsp_o),
    .pid_o        (rsp_pid_o),
    .len_o        (rsp_len_o),
    .short_o      (rsp_short_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maxp_q       <= '0;
      send_stall_q <= 1'b0;
      sent_stall_q <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      if (maxp_we) maxp_q <= reg_wdata_i[MAXP_W-1:0];
      if (csr_we)  send_stall_q <= reg_wdata_i[CSR_SEND_STALL];
      // hardware set wins over a same-cycle software clear
      if (stall_hit)                                       sent_stall_q <= 1'b1;
      else if (csr_we && !reg_wdata_i[CSR_SENT_STALL])     sent_stall_q <= 1'b0;
      irq_q <= pop || stall_hit || (push && dbl_buf_en_i && cnt == '0);
    end
  end

  always_comb begin
    csr_rd                 = '0;
    csr_rd[CSR_RDY]        = full;
    csr_rd[CSR_SEND_STALL] = send_stall_q;
    csr_rd[CSR_SENT_STALL] = sent_stall_q;
  end

  assign reg_rdata_o = reg_addr_i ? DATA_W'(maxp_q) : csr_rd;
  assign irq_o       = irq_q;
endmodule

// File: rtl/bulk_in_tx_ctrl_chk.sv
module bulk_in_tx_ctrl_chk #(
  parameter int NSLOT = 2,
  parameter int CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_token_i,
  input logic             tx_ack_i,
  input logic             tx_timeout_i,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_o,
  input logic             irq_o,
  input logic             send_stall,
  input logic             sent_stall,
  input logic             csr_we,
  input logic             clr_tog,
  input logic             tog,
  input logic [CNT_W-1:0] cnt
);
  a_r2_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(NSLOT));

  a_r5_rsp_follows_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(in_token_i));

  a_r9_stall_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_token_i && send_stall |=> rsp_valid_o && rsp_o == 2'b10 && irq_o && sent_stall);

  a_r9_stall_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_stall && !csr_we |=> send_stall);

  a_r6_timeout_keeps_tog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_timeout_i && !tx_ack_i && !clr_tog |=> $stable(tog));

  a_r11_clr_tog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_tog |=> !tog);
endmodule

bind bulk_in_tx_ctrl bulk_in_tx_ctrl_chk #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_token_i   (in_token_i),
  .tx_ack_i     (tx_ack_i),
  .tx_timeout_i (tx_timeout_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_o        (rsp_o),
  .irq_o        (irq_o),
  .send_stall   (send_stall_q),
  .sent_stall   (sent_stall_q),
  .csr_we       (csr_we),
  .clr_tog      (clr_tog),
  .tog          (tog),
  .cnt          (cnt)
);

// File: tb/bulk_in_tx_ctrl_bench.sv
`timescale 1ns/1ps
module bulk_in_tx_ctrl_bench;
  localparam int OP_LOAD = 0, OP_TOK = 1, OP_ACK = 2, OP_TMO = 3;
  localparam logic [1:0] NAK = 2'b00, DAT = 2'b01, STL = 2'b10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        dbl = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic [11:0] load_len = '0, rsp_len;
  logic        token = 1'b0, ack = 1'b0, tmo = 1'b0;
  logic        rsp_valid, rsp_pid, rsp_short, irq;
  logic [1:0]  rsp;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bulk_in_tx_ctrl u_bulk_in_tx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dbl_buf_en_i(dbl),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .load_len_i(load_len), .in_token_i(token), .tx_ack_i(ack), .tx_timeout_i(tmo),
    .rsp_valid_o(rsp_valid), .rsp_o(rsp), .rsp_pid_o(rsp_pid), .rsp_len_o(rsp_len),
    .rsp_short_o(rsp_short), .irq_o(irq)
  );

  // {op[31:30], len[29:18], irq[17], rv[16], rsp[15:14], pid[13], rdy[12], elen[11:0]}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1, 12'd0,  1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 12'd0},
    {2'd0, 12'd64, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 12'd0},
    {2'd0, 12'd10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 12'd0},
    {2'd1, 12'd0,  1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 12'd64},
    {2'd3, 12'd0,  1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 12'd0},
    {2'd1, 12'd0,  1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 12'd64},
    {2'd2, 12'd0,  1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 12'd0},
    {2'd0, 12'd0,  1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 12'd0},
    {2'd1, 12'd0,  1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 12'd0},
    {2'd2, 12'd0,  1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 12'd0},
    {2'd1, 12'd0,  1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 12'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive for one edge; returns at the next falling edge with outputs settled
  task automatic op(input int code, input int len);
    @(negedge clk);
    case (code)
      OP_LOAD: begin we = 1'b1; addr = 1'b0; wdata = 16'h0001; load_len = 12'(len); end
      OP_TOK:  token = 1'b1;
      OP_ACK:  ack = 1'b1;
      default: tmo = 1'b1;
    endcase
    @(negedge clk);
    we = 1'b0; token = 1'b0; ack = 1'b0; tmo = 1'b0; wdata = '0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 1'b0; wdata = '0;
  endtask

  task automatic rd_maxp(output int v);
    addr = 1'b1; #0.5; v = rdata; addr = 1'b0; #0.5;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "csr", rdata, 0);
    rd_maxp(v); chk("R1", "maxp", v, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    // R8 low 11 bits only
    wr(1'b1, 16'hFFFF); rd_maxp(v); chk("R8", "maxp width", v, 16'h07FF);
    wr(1'b1, 16'd64);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      e = VEC[i];
      op(int'(e[31:30]), int'(e[29:18]));
      chk("R3", $sformatf("irq step %0d", i), irq, e[17]);
      chk("R5", $sformatf("rsp_valid step %0d", i), rsp_valid, e[16]);
      if (e[16]) chk("R5", $sformatf("rsp step %0d", i), rsp, e[15:14]);
      if (e[16] && e[15:14] == DAT) begin
        chk("R6", $sformatf("pid step %0d", i), rsp_pid, e[13]);
        chk("R7", $sformatf("len step %0d", i), rsp_len, e[11:0]);
      end
      chk("R2", $sformatf("ready bit step %0d", i), rdata[0], e[12]);
    end

    // R8 short packet flag
    op(OP_LOAD, 10); op(OP_TOK, 0);
    chk("R8", "short", rsp_short, 1); chk("R8", "len", rsp_len, 10);
    op(OP_ACK, 0);
    // R11 clear toggle (toggle is 1 here)
    wr(1'b0, 16'h0040); chk("R11", "bit6 reads 0", rdata, 0);
    op(OP_LOAD, 5); op(OP_TOK, 0); chk("R11", "pid after clear", rsp_pid, 0);
    op(OP_ACK, 0);

    // R4 double buffering, toggle now 1
    dbl = 1'b1;
    op(OP_LOAD, 20); chk("R4", "irq first", irq, 1); chk("R4", "rdy first", rdata[0], 0);
    op(OP_LOAD, 30); chk("R4", "irq second", irq, 0); chk("R4", "rdy second", rdata[0], 1);
    op(OP_LOAD, 40); chk("R2", "full ignore", rdata[0], 1);
    op(OP_TOK, 0); chk("R4", "order a", rsp_len, 20); chk("R4", "pid a", rsp_pid, 1);
    op(OP_ACK, 0); chk("R3", "irq ack", irq, 1); chk("R4", "rdy after ack", rdata[0], 0);
    op(OP_TOK, 0); chk("R4", "order b", rsp_len, 30); chk("R4", "pid b", rsp_pid, 0);
    op(OP_ACK, 0);
    op(OP_TOK, 0); chk("R5", "nak empty", rsp, NAK);

    // R9 / R10 stall
    op(OP_LOAD, 7);
    wr(1'b0, 16'h0010);
    op(OP_TOK, 0);
    chk("R9", "stall rsp", rsp, STL); chk("R9", "stall irq", irq, 1);
    chk("R9", "csr", rdata, 16'h0030);
    op(OP_TOK, 0);
    chk("R9", "stall again", rsp, STL); chk("R9", "irq again", irq, 1);
    wr(1'b0, 16'h0030); chk("R10", "write1 keeps", rdata, 16'h0030);
    wr(1'b0, 16'h0010); chk("R10", "write0 clears", rdata, 16'h0010);
    wr(1'b0, 16'h0000);
    op(OP_TOK, 0);
    chk("R9", "queued kept", rsp, DAT); chk("R9", "queued len", rsp_len, 7);
    chk("R9", "pid", rsp_pid, 1);
    op(OP_ACK, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule